// File: doc/BRIEF.md
# Variable-Length Instruction Decode Sequencer

This block sits at the front of a small 16-bit processor. It walks a 64K byte-addressed program memory one byte per handshake, beginning at the program counter. It turns each variable-length instruction into a decoded bundle for the execute stage: the operation number, the two source operands, and up to two destination register numbers. An opcode byte carries a six-bit operation number in bits [5:0]. Bits 6 and 7 tell whether the first and second source operands follow as a one-byte register number or as a two-byte little-endian immediate. How many operands follow, and what role each plays, depends on the operation.

The sequencer also handles the five predicate opcodes. Each one tests the greater and equal flag inputs in the cycle its opcode byte is accepted. When the test fails, the following instruction is still fetched byte for byte, so the program counter lands after it, but no bundle is issued for it. The execute stage consumes each bundle in the one cycle it is presented and holds the flag inputs current. The register file, arithmetic, multiply/divide and the stack side of the call operation lie outside this block.

Top module: `tvd_decode_seq`

## Requirements
- R1: While `rst_n` is low, `mem_req`, `dec_valid` and `dec_illegal` are low and `mem_addr` equals `RESET_PC` (default 0). After release, fetching starts at `RESET_PC`.
- R2: Each byte is taken in a cycle with `mem_req` and `mem_rdy` both high, and `mem_addr` then steps by one. The address wraps from 0xFFFF to 0x0000, so a program starting at 0xFFFE decodes across the wrap.
- R3: While `mem_rdy` is low, `mem_addr` holds and no decode progress or new bundle occurs.
- R4: When opcode bit 6 is 0, the first source is one byte whose low four bits give the register number. `dec_src1` carries the number zero-extended and `dec_src1_imm` is 0. Bytes 0x01,0x00,0x05 give operation 1, source register 0, destination register 5.
- R5: When opcode bit 6 is 1, the first source is two bytes, low byte first, and `dec_src1_imm` is 1. Bytes 0x41,0xAD,0xDE,0x05 give operation 1 with immediate 0xDEAD and destination register 5.
- R6: Opcode bit 7 selects the encoding of the second source in the same way, on operations that take two sources. These are 0x0A–0x0C, 0x0E, 0x0F, 0x11–0x15, 0x1E–0x24.
- R7: Destination operands are always one register byte. Bits 6 and 7 have no effect on an operand the operation does not treat as a source. Operations 0x00 and 0x16–0x1D take no operands. Operations 0x01–0x05, 0x07 and 0x08 take one source and one destination. Operation 0x2E takes one source only. Operation 0x0D takes one register byte that is reported as both `dec_src1` and `dec_dst1`.
- R8: Operations 0x1E and 0x20 take two destination bytes after the sources: the high-half register first (`dec_dst1`), then the low-half register (`dec_dst2`).
- R9: Any bundle field the operation does not use reads as zero, including the immediate flags.
- R10: `dec_valid` is a one-cycle pulse in the cycle after the instruction's last byte is taken. In that cycle, the bundle fields and `mem_addr` (the address following the instruction) are valid.
- R11: Predicates 0x25–0x29 issue their own bundle with no operands. Their conditions, on flags sampled when the opcode byte is taken, are: 0x25 greater; 0x26 greater or equal; 0x27 equal; 0x28 not greater or equal; 0x29 not greater.
- R12: After a failed predicate, the next instruction is consumed whole with neither `dec_valid` nor `dec_illegal`. A skipped predicate is not evaluated, so skips do not chain.
- R13: Operations 0x06, 0x09, 0x10, 0x2A–0x2D and 0x2F–0x3F consume only the opcode byte and pulse `dec_illegal` instead of `dec_valid`. `dec_op` shows the operation number and all other fields read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_req | output | 1 | Byte request valid |
| mem_addr | output | 16 | Byte address (program counter) |
| mem_rdy | input | 1 | Memory ready; the byte is taken when both are high |
| mem_rdata | input | 8 | Byte at `mem_addr`, valid while `mem_rdy` is high |
| flag_gt | input | 1 | Greater flag from the execute stage |
| flag_eq | input | 1 | Equal flag from the execute stage |
| dec_valid | output | 1 | Bundle pulse for an executed instruction |
| dec_illegal | output | 1 | Pulse for an unknown operation |
| dec_op | output | 6 | Operation number |
| dec_src1_imm | output | 1 | First source is an immediate |
| dec_src1 | output | 16 | First source immediate or register number |
| dec_src2_imm | output | 1 | Second source is an immediate |
| dec_src2 | output | 16 | Second source immediate or register number |
| dec_dst1 | output | 4 | First destination register (high half for wide products) |
| dec_dst2 | output | 4 | Second destination register (low half) |

## Verification
The scoreboard compares each bundle and the address in its pulse cycle. A wrong operand length therefore shows up as a shifted address, and as garbage fields in every bundle that follows. Opcodes with bits 6 and 7 set on operations that have fewer sources target a sequencer that obeys those bits blindly: it would fetch an extra byte. Each predicate is driven with flag values that make it both pass and fail. One failed predicate is followed by another predicate and one by an illegal opcode. A design that evaluated a skipped predicate or raised a flag for skipped code would issue an unexpected pulse or drop the next bundle. A second instance starts at 0xFFFE to catch an address that fails to wrap, and a ready pattern with a long hold catches progress made without a handshake.

// File: rtl/tvd_pkg.sv
// Shared types and encodings for the instruction decode sequencer.
// Assumes a 16-bit data word and sixteen registers.
package tvd_pkg;
    localparam int OPW = 6;   // operation number width
    localparam int RNW = 4;   // register number width
    localparam int WW  = 16;  // data word width
    localparam int BW  = 8;   // memory byte width

    // Fetch step of the byte walker
    typedef enum logic [2:0] {
        ST_OPC, ST_S1L, ST_S1H, ST_S2L, ST_S2H, ST_D1, ST_D2
    } step_t;

    // Operand layout of one operation
    typedef struct packed {
        logic       legal;   // operation exists
        logic       is_if;   // predicate opcode
        logic       srcdst;  // single register byte is source and destination
        logic [1:0] n_src;   // number of source operands
        logic [1:0] n_dst;   // number of destination register bytes
    } layout_t;

    localparam logic [OPW-1:0] OP_IFG  = 6'h25;
    localparam logic [OPW-1:0] OP_IFGE = 6'h26;
    localparam logic [OPW-1:0] OP_IFE  = 6'h27;
    localparam logic [OPW-1:0] OP_IFLE = 6'h28;
    localparam logic [OPW-1:0] OP_IFL  = 6'h29;
endpackage

// File: rtl/tvd_op_table.sv
// Operation layout table: maps a six-bit operation number to its operand
// roles. Purely combinational; assumes unknown numbers are reported illegal.
module tvd_op_table
    import tvd_pkg::*;
(
    input  logic [OPW-1:0] op,
    output layout_t        lay
);
    // Classify the operation into its operand layout
    always_comb begin
        lay = '{legal: 1'b1, is_if: 1'b0, srcdst: 1'b0, n_src: 2'd0, n_dst: 2'd0};
        unique casez (op)
            6'h00, 6'h16, 6'h17, 6'h18, 6'h19,
            6'h1A, 6'h1B, 6'h1C, 6'h1D: ;
            6'h01, 6'h02, 6'h03, 6'h04, 6'h05,
            6'h07, 6'h08: begin
                lay.n_src = 2'd1;
                lay.n_dst = 2'd1;
            end
            6'h0D: begin
                lay.srcdst = 1'b1;
                lay.n_dst  = 2'd1;
            end
            6'h0A, 6'h0B, 6'h0C, 6'h0E, 6'h0F,
            6'h11, 6'h12, 6'h13, 6'h14, 6'h15,
            6'h1F, 6'h21, 6'h22, 6'h23: begin
                lay.n_src = 2'd2;
                lay.n_dst = 2'd1;
            end
            6'h1E, 6'h20: begin
                lay.n_src = 2'd2;
                lay.n_dst = 2'd2;
            end
            6'h24: lay.n_src = 2'd2;
            6'h25, 6'h26, 6'h27, 6'h28, 6'h29: lay.is_if = 1'b1;
            6'h2E: lay.n_src = 2'd1;
            default: lay.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/tvd_cond_eval.sv
// Predicate evaluator: decides whether the instruction after a predicate
// runs. Non-predicate numbers always yield "take".
module tvd_cond_eval
    import tvd_pkg::*;
(
    input  logic [OPW-1:0] op,
    input  logic           gt,
    input  logic           eq,
    output logic           take
);
    // Evaluate the flag condition of the predicate
    always_comb begin
        unique case (op)
            OP_IFG:  take = gt;
            OP_IFGE: take = gt | eq;
            OP_IFE:  take = eq;
            OP_IFLE: take = ~gt | eq;
            OP_IFL:  take = ~gt;
            default: take = 1'b1;
        endcase
    end
endmodule

// File: rtl/tvd_decode_seq.sv
// Variable-length instruction decode sequencer. Fetches one byte per
// ready/valid handshake from RESET_PC, walks opcode, sources and
// destinations, and pulses a decoded bundle one cycle after the last byte.
// Assumes the consumer takes each bundle in its pulse cycle and keeps the
// flag inputs current when a predicate opcode is fetched.
module tvd_decode_seq
    import tvd_pkg::*;
#(
    parameter int           AW       = 16,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic           mem_req,
    output logic [AW-1:0]  mem_addr,
    input  logic           mem_rdy,
    input  logic [BW-1:0]  mem_rdata,
    input  logic           flag_gt,
    input  logic           flag_eq,
    output logic           dec_valid,
    output logic           dec_illegal,
    output logic [OPW-1:0] dec_op,
    output logic           dec_src1_imm,
    output logic [WW-1:0]  dec_src1,
    output logic           dec_src2_imm,
    output logic [WW-1:0]  dec_src2,
    output logic [RNW-1:0] dec_dst1,
    output logic [RNW-1:0] dec_dst2
);
    localparam int PADI = WW - BW;   // zero bits above an immediate low byte
    localparam int PADR = WW - RNW;  // zero bits above a register number

    step_t         step, nxt;
    logic [AW-1:0] pc;
    logic [BW-1:0] opc_q;
    logic [BW-1:0] cur_opc;
    logic          skip_q;
    logic          xfer, last, take, s1_imm, s2_imm;
    layout_t       lay;

    assign xfer     = mem_req & mem_rdy;
    assign mem_addr = pc;
    assign cur_opc  = (step == ST_OPC) ? mem_rdata : opc_q;

    tvd_op_table u_tab (
        .op  (cur_opc[OPW-1:0]),
        .lay (lay)
    );

    tvd_cond_eval u_cond (
        .op   (cur_opc[OPW-1:0]),
        .gt   (flag_gt),
        .eq   (flag_eq),
        .take (take)
    );

    // Source encodings chosen by opcode bits 6 and 7, only where a source exists
    assign s1_imm = cur_opc[6] & (lay.n_src != 2'd0) & ~lay.srcdst;
    assign s2_imm = cur_opc[7] & (lay.n_src == 2'd2);

    // Next fetch step and end-of-instruction detection
    always_comb begin
        nxt  = ST_OPC;
        last = 1'b0;
        unique case (step)
            ST_OPC: begin
                if (!lay.legal)              last = 1'b1;
                else if (lay.n_src != 2'd0)  nxt  = ST_S1L;
                else if (lay.n_dst != 2'd0)  nxt  = ST_D1;
                else                         last = 1'b1;
            end
            ST_S1L, ST_S1H: begin
                if (step == ST_S1L && s1_imm) nxt  = ST_S1H;
                else if (lay.n_src == 2'd2)   nxt  = ST_S2L;
                else if (lay.n_dst != 2'd0)   nxt  = ST_D1;
                else                          last = 1'b1;
            end
            ST_S2L, ST_S2H: begin
                if (step == ST_S2L && s2_imm) nxt  = ST_S2H;
                else if (lay.n_dst != 2'd0)   nxt  = ST_D1;
                else                          last = 1'b1;
            end
            ST_D1: begin
                if (lay.n_dst == 2'd2) nxt  = ST_D2;
                else                   last = 1'b1;
            end
            ST_D2:   last = 1'b1;
            default: last = 1'b1;
        endcase
    end

    // Program counter, fetch step, request enable and skip state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc      <= RESET_PC;
            step    <= ST_OPC;
            mem_req <= 1'b0;
            skip_q  <= 1'b0;
            opc_q   <= '0;
        end else begin
            mem_req <= 1'b1;
            if (xfer) begin
                pc   <= pc + AW'(1);
                step <= nxt;
                if (step == ST_OPC) opc_q <= mem_rdata;
                if (last) skip_q <= skip_q ? 1'b0 : (lay.is_if & ~take);
            end
        end
    end

    // Bundle field capture as operand bytes arrive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_op       <= '0;
            dec_src1_imm <= 1'b0;
            dec_src1     <= '0;
            dec_src2_imm <= 1'b0;
            dec_src2     <= '0;
            dec_dst1     <= '0;
            dec_dst2     <= '0;
        end else if (xfer) begin
            unique case (step)
                ST_OPC: begin
                    dec_op       <= mem_rdata[OPW-1:0];
                    dec_src1_imm <= s1_imm & lay.legal;
                    dec_src2_imm <= s2_imm & lay.legal;
                    dec_src1     <= '0;
                    dec_src2     <= '0;
                    dec_dst1     <= '0;
                    dec_dst2     <= '0;
                end
                ST_S1L: dec_src1 <= s1_imm ? {{PADI{1'b0}}, mem_rdata}
                                           : {{PADR{1'b0}}, mem_rdata[RNW-1:0]};
                ST_S1H: dec_src1[WW-1:BW] <= mem_rdata;
                ST_S2L: dec_src2 <= s2_imm ? {{PADI{1'b0}}, mem_rdata}
                                           : {{PADR{1'b0}}, mem_rdata[RNW-1:0]};
                ST_S2H: dec_src2[WW-1:BW] <= mem_rdata;
                ST_D1: begin
                    dec_dst1 <= mem_rdata[RNW-1:0];
                    if (lay.srcdst) dec_src1 <= {{PADR{1'b0}}, mem_rdata[RNW-1:0]};
                end
                ST_D2:   dec_dst2 <= mem_rdata[RNW-1:0];
                default: ;
            endcase
        end
    end

    // One-cycle result pulses, suppressed for a skipped instruction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid   <= 1'b0;
            dec_illegal <= 1'b0;
        end else begin
            dec_valid   <= xfer & last & lay.legal & ~skip_q;
            dec_illegal <= xfer & last & ~lay.legal & ~skip_q;
        end
    end

    // R2: every accepted byte advances the address by exactly one, wrapping
    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> (mem_addr == AW'($past(mem_addr) + AW'(1))));

    // R3: without ready the address and the fetch step hold
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy) |=> ($stable(mem_addr) && $stable(step)));

    // R10: a bundle pulse only follows an accepted byte
    a_r10_pulse_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid || dec_illegal) |-> $past(xfer));

    // R12: the instruction after a failed predicate issues nothing
    a_r12_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && last && skip_q) |=> (!dec_valid && !dec_illegal));

    // R13: an unknown operation consumes only its opcode byte
    a_r13_one_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && step == ST_OPC && !lay.legal) |=> (step == ST_OPC));

    // R13: the two result pulses never coincide
    a_r13_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_valid && dec_illegal));
endmodule

// File: tb/tb_tvd_decode_seq.sv
module tb_tvd_decode_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req, mem_rdy;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic        flag_gt, flag_eq;
    logic        dec_valid, dec_illegal, dec_src1_imm, dec_src2_imm;
    logic [5:0]  dec_op;
    logic [15:0] dec_src1, dec_src2;
    logic [3:0]  dec_dst1, dec_dst2;

    // wrap instance signals
    logic        w_req, w_valid, w_ill, w_i1, w_i2;
    logic [15:0] w_addr, w_s1, w_s2;
    logic [7:0]  w_rdata;
    logic [5:0]  w_op;
    logic [3:0]  w_d1, w_d2;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int wp = 0;
    bit skip_next = 0;
    bit hold_ok = 1;
    logic [15:0] hold_addr;

    logic [7:0] prog [256];
    logic       fgt [256];
    logic       feq [256];
    logic [7:0] progw [4];

    typedef struct {
        bit          ill;
        logic [5:0]  op;
        bit          i1, i2;
        logic [15:0] s1, s2;
        logic [3:0]  d1, d2;
        logic [15:0] endpc;
        string       req;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    assign mem_rdata = prog[mem_addr[7:0]];
    assign flag_gt   = fgt[mem_addr[7:0]];
    assign flag_eq   = feq[mem_addr[7:0]];
    assign w_rdata   = progw[w_addr[1:0]];

    tvd_decode_seq dut (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdy(mem_rdy), .mem_rdata(mem_rdata), .flag_gt(flag_gt), .flag_eq(flag_eq),
        .dec_valid(dec_valid), .dec_illegal(dec_illegal), .dec_op(dec_op),
        .dec_src1_imm(dec_src1_imm), .dec_src1(dec_src1),
        .dec_src2_imm(dec_src2_imm), .dec_src2(dec_src2),
        .dec_dst1(dec_dst1), .dec_dst2(dec_dst2)
    );

    tvd_decode_seq #(.RESET_PC(16'hFFFE)) dut_wrap (
        .clk(clk), .rst_n(rst_n), .mem_req(w_req), .mem_addr(w_addr),
        .mem_rdy(1'b1), .mem_rdata(w_rdata), .flag_gt(1'b0), .flag_eq(1'b0),
        .dec_valid(w_valid), .dec_illegal(w_ill), .dec_op(w_op),
        .dec_src1_imm(w_i1), .dec_src1(w_s1), .dec_src2_imm(w_i2), .dec_src2(w_s2),
        .dec_dst1(w_d1), .dec_dst2(w_d2)
    );

    task automatic check(input bit ok, input string req, input string what);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    task automatic put(input logic [7:0] b);
        prog[wp[7:0]] = b;
        wp++;
    endtask

    // Driver: encode one instruction and queue its expected bundle
    task automatic ins(input logic [7:0] opc, input int ns, input int nd, input bit sd,
                       input logic [15:0] v1, input logic [15:0] v2,
                       input logic [3:0] d1, input logic [3:0] d2, input string req);
        exp_t e;
        bit i1 = opc[6] && ns >= 1 && !sd;
        bit i2 = opc[7] && ns == 2;
        put(opc);
        if (sd) put({4'h0, d1});
        else begin
            if (ns >= 1) begin put(v1[7:0]); if (i1) put(v1[15:8]); end
            if (ns == 2) begin put(v2[7:0]); if (i2) put(v2[15:8]); end
            if (nd >= 1) put({4'h0, d1});
            if (nd == 2) put({4'h0, d2});
        end
        e.ill = 0; e.op = opc[5:0]; e.i1 = i1; e.i2 = i2;
        e.s1 = sd ? {12'h0, d1} : (ns >= 1 ? (i1 ? v1 : {12'h0, v1[3:0]}) : 16'h0);
        e.s2 = ns == 2 ? (i2 ? v2 : {12'h0, v2[3:0]}) : 16'h0;
        e.d1 = (nd >= 1 || sd) ? d1 : 4'h0;
        e.d2 = nd == 2 ? d2 : 4'h0;
        e.endpc = wp[15:0]; e.req = req;
        if (skip_next) skip_next = 0;
        else q.push_back(e);
    endtask

    task automatic ill(input logic [7:0] opc, input string req);
        exp_t e;
        put(opc);
        e.ill = 1; e.op = opc[5:0]; e.i1 = 0; e.i2 = 0; e.s1 = 0; e.s2 = 0;
        e.d1 = 0; e.d2 = 0; e.endpc = wp[15:0]; e.req = req;
        if (skip_next) skip_next = 0;
        else q.push_back(e);
    endtask

    // Predicate: flags presented at its address, skip decided from R11
    task automatic pred(input logic [7:0] opc, input bit gt, input bit eq, input string req);
        bit cond;
        bit was_skipped = skip_next;
        fgt[wp[7:0]] = gt;
        feq[wp[7:0]] = eq;
        case (opc[5:0])
            6'h25: cond = gt;
            6'h26: cond = gt || eq;
            6'h27: cond = eq;
            6'h28: cond = !gt || eq;
            default: cond = !gt;
        endcase
        ins(opc, 0, 0, 0, 0, 0, 0, 0, req);
        if (!was_skipped) skip_next = !cond;
    endtask

    // Monitor: pop and compare each bundle pulse
    always @(negedge clk) begin
        if (rst_n && (dec_valid || dec_illegal) && q.size() != 0) begin
            exp_t e;
            e = q.pop_front();
            check(dec_illegal == e.ill && dec_valid == !e.ill && dec_op == e.op &&
                  dec_src1_imm == e.i1 && dec_src1 == e.s1 &&
                  dec_src2_imm == e.i2 && dec_src2 == e.s2 &&
                  dec_dst1 == e.d1 && dec_dst2 == e.d2, e.req,
                  $sformatf("got ill=%0b op=%h i1=%0b s1=%h i2=%0b s2=%h d1=%h d2=%h exp ill=%0b op=%h i1=%0b s1=%h i2=%0b s2=%h d1=%h d2=%h",
                            dec_illegal, dec_op, dec_src1_imm, dec_src1, dec_src2_imm, dec_src2,
                            dec_dst1, dec_dst2, e.ill, e.op, e.i1, e.s1, e.i2, e.s2, e.d1, e.d2));
            check(mem_addr == e.endpc, "R2",
                  $sformatf("address at pulse got %h exp %h (op %h)", mem_addr, e.endpc, e.op));
        end
    end

    // Ready pattern with a long hold window; the R3 hold check lives here
    initial begin
        mem_rdy = 1'b1;
        forever begin
            @(negedge clk);
            cyc++;
            mem_rdy = (cyc >= 40 && cyc <= 47) ? 1'b0 : ((cyc % 5) != 3);
            if (cyc == 41) hold_addr = mem_addr;
            if (cyc >= 42 && cyc <= 47) begin
                if (mem_addr != hold_addr || dec_valid || dec_illegal) hold_ok = 0;
            end
            if (cyc == 47)
                check(hold_ok, "R3", $sformatf("hold: addr %h exp %h, pulse seen=%0b",
                                               mem_addr, hold_addr, !hold_ok));
        end
    end

    // Wrap instance: first bundle spans 0xFFFE..0x0001 (R2, R5)
    initial begin
        bit seen = 0;
        progw[2] = 8'h41; progw[3] = 8'h34; progw[0] = 8'h12; progw[1] = 8'h07;
        @(posedge rst_n);
        for (int i = 0; i < 40 && !seen; i++) begin
            @(negedge clk);
            if (w_valid) begin
                seen = 1;
                check(w_op == 6'h01 && w_i1 && w_s1 == 16'h1234 && w_d1 == 4'h7 &&
                      w_addr == 16'h0002 && !w_i2 && w_s2 == 0 && w_d2 == 0, "R2",
                      $sformatf("wrap got op=%h s1=%h d1=%h addr=%h exp op=01 s1=1234 d1=7 addr=0002",
                                w_op, w_s1, w_d1, w_addr));
            end
        end
        if (!seen) check(0, "R2", "wrap got no bundle exp one bundle");
    end

    initial begin
        for (int i = 0; i < 256; i++) begin prog[i] = 8'h00; fgt[i] = 0; feq[i] = 0; end
        ins(8'h01, 1, 1, 0, 16'h0000, 0, 4'h5, 0, "R4");
        ins(8'h41, 1, 1, 0, 16'hDEAD, 0, 4'h5, 0, "R5");
        ins(8'h12, 2, 1, 0, 16'h3, 16'h4, 4'h9, 0, "R6");
        ins(8'h92, 2, 1, 0, 16'h2, 16'h1234, 4'hA, 0, "R6");
        ins(8'hD4, 2, 1, 0, 16'h8001, 16'h7FFE, 4'hF, 0, "R6");
        ins(8'h4F, 2, 1, 0, 16'hA5C3, 16'h6, 4'h1, 0, "R5");
        ins(8'hCD, 0, 1, 1, 0, 0, 4'h7, 0, "R7");
        ins(8'hC0, 0, 0, 0, 0, 0, 0, 0, "R7");
        ins(8'h17, 0, 0, 0, 0, 0, 0, 0, "R10");
        ins(8'hEE, 1, 0, 0, 16'hBEEF, 0, 0, 0, "R7");
        ins(8'h24, 2, 0, 0, 16'h1, 16'h2, 0, 0, "R9");
        ins(8'h9E, 2, 2, 0, 16'h6, 16'h00FF, 4'h3, 4'h4, "R8");
        ins(8'h20, 2, 2, 0, 16'h1, 16'h2, 4'hE, 4'hD, "R8");
        ins(8'h84, 1, 1, 0, 16'h8, 0, 4'hC, 0, "R7");
        ill(8'h06, "R13");
        ill(8'hFF, "R13");
        ill(8'h2B, "R13");
        ins(8'h01, 1, 1, 0, 16'h2, 0, 4'h3, 0, "R13");
        pred(8'h25, 1, 0, "R11");  ins(8'h01, 1, 1, 0, 16'h1, 0, 4'h2, 0, "R11");
        pred(8'h25, 0, 0, "R11");  ins(8'hD2, 2, 1, 0, 16'h1111, 16'h2222, 4'h3, 0, "R12");
        ins(8'h01, 1, 1, 0, 16'h4, 0, 4'h5, 0, "R12");
        pred(8'h26, 0, 1, "R11");  ins(8'h00, 0, 0, 0, 0, 0, 0, 0, "R11");
        pred(8'h26, 0, 0, "R11");  ins(8'h6E, 1, 0, 0, 16'h4321, 0, 0, 0, "R12");
        pred(8'h27, 0, 1, "R11");  ins(8'h00, 0, 0, 0, 0, 0, 0, 0, "R11");
        pred(8'h27, 0, 0, "R11");  ill(8'h06, "R12");
        ins(8'h01, 1, 1, 0, 16'h6, 0, 4'h7, 0, "R12");
        pred(8'h28, 1, 0, "R11");  ins(8'hDE, 2, 2, 0, 16'h1, 16'h2, 4'h3, 4'h4, "R12");
        pred(8'h28, 1, 1, "R11");  ins(8'h01, 1, 1, 0, 16'h8, 0, 4'h9, 0, "R11");
        pred(8'h28, 0, 0, "R11");  ins(8'h01, 1, 1, 0, 16'hA, 0, 4'hB, 0, "R11");
        pred(8'h29, 1, 0, "R11");  pred(8'h27, 0, 0, "R12");
        ins(8'h01, 1, 1, 0, 16'hC, 0, 4'hD, 0, "R12");
        pred(8'h29, 0, 1, "R11");  ins(8'h41, 1, 1, 0, 16'h0F0F, 0, 4'hE, 0, "R11");
        ins(8'h13, 2, 1, 0, 16'h5, 16'h6, 4'h7, 0, "R6");

        repeat (4) @(negedge clk);
        check(!mem_req && !dec_valid && !dec_illegal && mem_addr == 16'h0000, "R1",
              $sformatf("in reset got req=%0b v=%0b ill=%0b addr=%h exp 0 0 0 0000",
                        mem_req, dec_valid, dec_illegal, mem_addr));
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_addr == 16'h0000 && !dec_valid, "R1",
              $sformatf("after reset got addr=%h v=%0b exp 0000 0", mem_addr, dec_valid));
        for (int i = 0; i < 20000 && q.size() != 0; i++) @(negedge clk);
        if (q.size() != 0)
            check(0, "R10", $sformatf("watchdog: got %0d bundles pending exp 0", q.size()));
        repeat (5) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule